// File: doc/BRIEF.md
# Externally Strobed FIFO Bus Port

This port moves 16-bit words between an external device and a pair of internal FIFOs. The external device owns the timing: it drives a combined clock/strobe line and a direction level, and the port reacts to each rising edge of that strobe. A high direction level at the edge asks the port to put out the next transmit word. A low level hands the port a word to store in the receive FIFO. Everything inside runs on the system clock. The strobe, the direction level and the incoming bus word are resynchronized and oversampled to find the strobe's rising edges.

The host fills the transmit FIFO and drains the receive FIFO through simple push/pop strobes. A read-request output tells the external device that transmit data is waiting, so it can also serve as a data-ready interrupt. Receive words that arrive while the receive FIFO is full are discarded, and a sticky overflow interrupt is raised. Reading out from an empty transmit FIFO sets a sticky underrun flag.

The port acts only while `cfg_mode_sel` is 1 and `cfg_clk_out` is 0. In any other setting, strobe edges do nothing.

Top module: `xstb_fifo_port`

## Requirements
- R1: The port acts only when `cfg_mode_sel`=1 and `cfg_clk_out`=0. Otherwise strobe edges neither pop nor push, `ext_oe` is 0 and `ext_rdreq` is 0.
- R2: A strobe edge with `ext_dir`=1 while the transmit FIFO holds data pops the oldest word onto `ext_dout` and sets `ext_oe`=1. These outputs update on the third system-clock rising edge after the strobe input rises.
- R3: A strobe edge with `ext_dir`=0 while the receive FIFO is not full stores the `ext_din` word. The host pops stored words in arrival order on `rx_rdata`.
- R4: A strobe edge with `ext_dir`=0 while the receive FIFO is full drops the word, leaves the FIFO level and contents unchanged, and sets `ovf_irq`.
- R5: `ovf_irq` stays set until a cycle with `ovf_clr`=1 clears it. A new overflow in that same cycle keeps it set.
- R6: `ext_rdreq` is 1 exactly while the port is active and the transmit FIFO holds data. It falls on the same system-clock edge that puts the last word onto `ext_dout`.
- R7: A read-out edge while the transmit FIFO is empty pops nothing, keeps the previous `ext_dout` value and `ext_oe`=1, and sets `udr_flag`. `udr_flag` stays set until reset.
- R8: `ext_oe` returns to 0 on a write-in strobe edge, in any cycle where the port is inactive, and in reset.
- R9: Each FIFO holds 8 words and reports its level, full and empty. A host push into a full transmit FIFO is ignored, and a host pop from an empty receive FIFO is ignored.
- R10: After reset both FIFOs are empty, and `ext_dout`=0, `ext_oe`=0, `ovf_irq`=0, `udr_flag`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode_sel | input | 1 | Mode select; must be 1 for the port to act |
| cfg_clk_out | input | 1 | Port-driven clock option; must be 0 for the port to act |
| tx_push | input | 1 | Host push into transmit FIFO |
| tx_wdata | input | 16 | Host word for transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | 4 | Transmit FIFO occupancy |
| rx_pop | input | 1 | Host pop from receive FIFO |
| rx_rdata | output | 16 | Oldest receive FIFO word |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | 4 | Receive FIFO occupancy |
| ovf_clr | input | 1 | Clears the overflow interrupt |
| ovf_irq | output | 1 | Sticky receive overflow interrupt |
| udr_flag | output | 1 | Sticky transmit underrun flag |
| ext_stb | input | 1 | External clock/strobe |
| ext_dir | input | 1 | External direction, 1 = read-out |
| ext_din | input | 16 | External bus word in |
| ext_dout | output | 16 | Bus word out |
| ext_oe | output | 1 | Bus output enable |
| ext_rdreq | output | 1 | Read-request / data-ready |

## Verification
A bad FIFO pointer or count shows up within one host pop or one strobe read-out, as a wrong word on `rx_rdata` or `ext_dout` or as a wrong level. A slip in the edge detector or synchronizer shows up at the third clock after a strobe rise. At that point `ext_dout`, `ext_oe` and `ext_rdreq` are sampled one clock before and one clock after the expected update. A lost sticky bit is seen on `ovf_irq` or `udr_flag` at the next host check, which comes several cycles later.

// File: rtl/xstb_pkg.sv
package xstb_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_RDOUT = 2'd1,
      CYC_WRIN  = 2'd2
   } cyc_e;

   function automatic int unsigned lvl_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/xstb_sync.sv
module xstb_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xstb_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xstb_cyc_dec.sv
module xstb_cyc_dec
   import xstb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic stb_s,
   input  logic dir_s,
   output cyc_e cyc
);
   logic stb_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_prev <= 1'b0;
      else        stb_prev <= stb_s;
   end

   always_comb begin
      cyc = CYC_IDLE;
      if (active && stb_s && !stb_prev) cyc = dir_s ? CYC_RDOUT : CYC_WRIN;
   end
endmodule

// File: rtl/xstb_fifo.sv
module xstb_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   push,
   input  logic [W-1:0]                           wdata,
   input  logic                                   pop,
   output logic [W-1:0]                           rdata,
   output logic                                   full,
   output logic                                   empty,
   output logic [xstb_pkg::lvl_bits(DEPTH)-1:0]   level
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LW = xstb_pkg::lvl_bits(DEPTH);
   localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("xstb_fifo depth must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("xstb_fifo width must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   assign do_push = push && (cnt != FULL_CNT);
   assign do_pop  = pop  && (cnt != '0);

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
   assign full  = (cnt == FULL_CNT);
   assign empty = (cnt == '0);
   assign level = cnt;
endmodule

// File: rtl/xstb_fifo_port.sv
module xstb_fifo_port
   import xstb_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LW         = xstb_pkg::lvl_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode_sel,
   input  logic              cfg_clk_out,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic              tx_full,
   output logic              tx_empty,
   output logic [LW-1:0]     tx_level,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_full,
   output logic              rx_empty,
   output logic [LW-1:0]     rx_level,
   input  logic              ovf_clr,
   output logic              ovf_irq,
   output logic              udr_flag,
   input  logic              ext_stb,
   input  logic              ext_dir,
   input  logic [DATA_W-1:0] ext_din,
   output logic [DATA_W-1:0] ext_dout,
   output logic              ext_oe,
   output logic              ext_rdreq
);
   localparam int unsigned SW = DATA_W + 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xstb_fifo_port needs two or more sync stages");
   end

   logic              active;
   logic [SW-1:0]     sync_d, sync_q;
   logic              stb_s, dir_s;
   logic [DATA_W-1:0] din_s;
   cyc_e              cyc;
   logic [DATA_W-1:0] tx_head;
   logic              rx_push;
   logic              tx_pop;

   assign active = cfg_mode_sel && !cfg_clk_out;

   // strobe, direction and bus word share one pipeline so they stay aligned
   assign sync_d = {ext_stb, ext_dir, ext_din};

   xstb_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_d),
      .q     (sync_q)
   );

   assign stb_s = sync_q[SW-1];
   assign dir_s = sync_q[SW-2];
   assign din_s = sync_q[DATA_W-1:0];

   xstb_cyc_dec u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .stb_s  (stb_s),
      .dir_s  (dir_s),
      .cyc    (cyc)
   );

   assign tx_pop  = (cyc == CYC_RDOUT) && !tx_empty;
   assign rx_push = (cyc == CYC_WRIN) && !rx_full;

   xstb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata (tx_wdata),
      .pop   (tx_pop),
      .rdata (tx_head),
      .full  (tx_full),
      .empty (tx_empty),
      .level (tx_level)
   );

   xstb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .wdata (din_s),
      .pop   (rx_pop),
      .rdata (rx_rdata),
      .full  (rx_full),
      .empty (rx_empty),
      .level (rx_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_dout <= '0;
         ext_oe   <= 1'b0;
         udr_flag <= 1'b0;
         ovf_irq  <= 1'b0;
      end else begin
         if (ovf_clr) ovf_irq <= 1'b0;
         if (!active) ext_oe <= 1'b0;
         case (cyc)
            CYC_RDOUT: begin
               ext_oe <= 1'b1;
               if (!tx_empty) ext_dout <= tx_head;
               else           udr_flag <= 1'b1;
            end
            CYC_WRIN: begin
               ext_oe <= 1'b0;
               if (rx_full) ovf_irq <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign ext_rdreq = active && !tx_empty;
endmodule

// File: rtl/xstb_fifo_port_chk.sv
module xstb_fifo_port_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned LW    = xstb_pkg::lvl_bits(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_mode_sel,
   input logic          cfg_clk_out,
   input logic          ovf_clr,
   input logic          ovf_irq,
   input logic          udr_flag,
   input logic          rx_full,
   input logic          rx_pop,
   input logic [LW-1:0] rx_level,
   input logic [LW-1:0] tx_level,
   input logic          ext_oe,
   input logic          ext_rdreq
);
   logic mode_ok;
   assign mode_ok = cfg_mode_sel && !cfg_clk_out;

   p_inactive_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ok |=> !ext_oe || mode_ok);

   p_rdreq_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ext_rdreq) && mode_ok && $past(mode_ok)) |-> (tx_level == '0 && $past(tx_level) == LW'(1)));

   p_ovf_only_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_irq) |-> ($past(rx_full) && (rx_level == $past(rx_level) || $past(rx_pop))));

   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_irq && !ovf_clr) |=> ovf_irq);

   p_udr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      udr_flag |=> udr_flag);

   p_tx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, tx_level} <= {1'b0, $past(tx_level)} + 1'b1) && ({1'b0, tx_level} + 1'b1 >= {1'b0, $past(tx_level)}));

   p_rx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= LW'(DEPTH));
endmodule

bind xstb_fifo_port xstb_fifo_port_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_mode_sel (cfg_mode_sel),
   .cfg_clk_out  (cfg_clk_out),
   .ovf_clr      (ovf_clr),
   .ovf_irq      (ovf_irq),
   .udr_flag     (udr_flag),
   .rx_full      (rx_full),
   .rx_pop       (rx_pop),
   .rx_level     (rx_level),
   .tx_level     (tx_level),
   .ext_oe       (ext_oe),
   .ext_rdreq    (ext_rdreq)
);

// File: tb/xstb_fifo_port_bench.sv
`timescale 1ns/1ps
module xstb_fifo_port_bench;
   localparam int DW = 16;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_mode_sel = 1'b1, cfg_clk_out = 1'b0;
   logic tx_push = 1'b0, rx_pop = 1'b0, ovf_clr = 1'b0;
   logic [DW-1:0] tx_wdata = '0, ext_din = '0;
   logic ext_stb = 1'b0, ext_dir = 1'b0;
   logic tx_full, tx_empty, rx_full, rx_empty, ovf_irq, udr_flag, ext_oe, ext_rdreq;
   logic [3:0] tx_level, rx_level;
   logic [DW-1:0] rx_rdata, ext_dout;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xstb_fifo_port u_xstb_fifo_port (
      .clk(clk), .rst_n(rst_n), .cfg_mode_sel(cfg_mode_sel), .cfg_clk_out(cfg_clk_out),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
      .tx_level(tx_level), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_full(rx_full),
      .rx_empty(rx_empty), .rx_level(rx_level), .ovf_clr(ovf_clr), .ovf_irq(ovf_irq),
      .udr_flag(udr_flag), .ext_stb(ext_stb), .ext_dir(ext_dir), .ext_din(ext_din),
      .ext_dout(ext_dout), .ext_oe(ext_oe), .ext_rdreq(ext_rdreq)
   );

   function automatic logic [DW-1:0] txw(input int i);
      return DW'(i * 16'h1357) ^ 16'hA5A5;
   endfunction
   function automatic logic [DW-1:0] rxw(input int i);
      return 16'hF00F ^ DW'(i << 4) ^ DW'(i);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_push(input logic [DW-1:0] w);
      @(negedge clk); tx_wdata = w; tx_push = 1'b1;
      @(negedge clk); tx_push = 1'b0;
   endtask

   task automatic host_pop();
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   // leaves caller at negedge N2 after the strobe rise; update lands at P3
   task automatic strobe_rise(input logic dir, input logic [DW-1:0] w);
      @(negedge clk); ext_dir = dir; ext_din = w;
      @(negedge clk); ext_stb = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic strobe_fall();
      @(negedge clk); ext_stb = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic ext_cycle(input logic dir, input logic [DW-1:0] w);
      strobe_rise(dir, w);
      @(negedge clk);
      strobe_fall();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 tx_empty", tx_empty, 1);
      check("R10 rx_empty", rx_empty, 1);
      check("R10 ext_oe", ext_oe, 0);
      check("R10 ext_dout", ext_dout, 0);
      check("R10 ovf_irq", ovf_irq, 0);
      check("R10 udr_flag", udr_flag, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9 fill tx, overfill ignored
      for (int i = 0; i < DEPTH + 1; i++) begin
         host_push(txw(i));
         check("R9 tx_level", tx_level, (i < DEPTH) ? i + 1 : DEPTH);
      end
      check("R9 tx_full", tx_full, 1);
      check("R6 rdreq with data", ext_rdreq, 1);

      // R2 read-out sweep, R6 exact fall on last word
      for (int i = 0; i < DEPTH; i++) begin
         strobe_rise(1'b1, '0);
         check("R2 pre-update level", tx_level, DEPTH - i);
         check("R6 rdreq before edge", ext_rdreq, 1);
         @(negedge clk);
         check("R2 ext_dout", ext_dout, txw(i));
         check("R2 ext_oe", ext_oe, 1);
         check("R2 tx_level", tx_level, DEPTH - 1 - i);
         check("R6 rdreq after edge", ext_rdreq, (i == DEPTH - 1) ? 0 : 1);
         strobe_fall();
      end

      // R7 underrun
      ext_cycle(1'b1, '0);
      check("R7 udr_flag", udr_flag, 1);
      check("R7 dout held", ext_dout, txw(DEPTH - 1));
      check("R7 ext_oe", ext_oe, 1);
      check("R7 tx_level", tx_level, 0);

      // R3 write-in sweep, R8 oe drop
      for (int i = 0; i < DEPTH; i++) begin
         ext_cycle(1'b0, rxw(i));
         check("R3 rx_level", rx_level, i + 1);
         if (i == 0) check("R8 oe low after write-in", ext_oe, 0);
      end
      check("R9 rx_full", rx_full, 1);
      // R4 overflow drops the word
      ext_cycle(1'b0, 16'hDEAD);
      check("R4 ovf_irq", ovf_irq, 1);
      check("R4 rx_level", rx_level, DEPTH);
      repeat (5) @(negedge clk);
      check("R5 ovf sticky", ovf_irq, 1);
      for (int i = 0; i < DEPTH; i++) begin
         check("R3 rx order", rx_rdata, rxw(i));
         host_pop();
      end
      check("R4 no extra word", rx_empty, 1);
      host_pop();
      check("R9 pop empty ignored", rx_level, 0);
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      check("R5 ovf cleared", ovf_irq, 0);
      check("R7 udr still set", udr_flag, 1);

      // R1 inactive: no pop, no push, rdreq low, oe low
      ext_cycle(1'b1, '0);
      check("R8 oe before mode change", ext_oe, 1);
      host_push(16'h7777);
      cfg_clk_out = 1'b1;
      @(negedge clk);
      check("R8 oe low inactive", ext_oe, 0);
      check("R1 rdreq inactive", ext_rdreq, 0);
      ext_cycle(1'b1, '0);
      check("R1 no pop", tx_level, 1);
      check("R1 oe stays low", ext_oe, 0);
      ext_cycle(1'b0, 16'h1234);
      check("R1 no push", rx_level, 0);
      cfg_clk_out = 1'b0; cfg_mode_sel = 1'b0;
      ext_cycle(1'b0, 16'h4321);
      check("R1 no push sel low", rx_level, 0);
      cfg_mode_sel = 1'b1;
      @(negedge clk);
      check("R1 rdreq back", ext_rdreq, 1);
      ext_cycle(1'b1, '0);
      check("R2 word after resume", ext_dout, 16'h7777);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule